// File: doc/BRIEF.md
# DRAM Low-Power Mode Sequencer

This block is the control state machine that moves a DDR2 or mobile-DDR memory interface into and out of its two low-power states: power-down and self-refresh. Software picks the state with two control bits. The sequencer then waits until the traffic it sees is idle: no access pending, no refresh owed, and no urgent refresh. It closes any open banks with a precharge-all. Then it issues the entry command and drops the clock-enable output (CKE) in that same cycle.

While CKE is low the sequencer watches for wake events. A wake cannot take effect until a programmed minimum residency has elapsed; earlier wakes are held. On leaving power-down, CKE rises together with a NOP and normal service resumes. An access that woke the block is served, and the block re-enters power-down by itself once traffic is idle again. On leaving self-refresh, CKE rises and NOPs are issued for a programmed delay. A mandatory auto-refresh then goes out before anything else.

Each cycle the block drives one command code, the CKE level and an access-grant strobe. The grant strobe tells the surrounding controller when it may issue accesses.

Top module: `dram_lowpow_seq`

## Requirements
- R1: After reset, `cke` is 1, `cmd` is 0 (NOP) and `acc_ok` is 1.
- R2: Low-power entry starts only when `lp_en`=1, `acc_pend`=0, `rfsh_backlog`=0 and `rfsh_urgent`=0 hold at a clock edge. If no bank is open, the entry command appears in the cycle after that edge.
- R3: If any bit of `bank_open` is set at the deciding edge, exactly one precharge-all cycle (`cmd`=1, `cke`=1) comes before the entry command.
- R4: With `pd_sel`=1, entry is `cmd`=2 (power-down, a NOP-class command) with `cke`=0 in the same cycle. Every later cycle with `cke` low carries `cmd`=0.
- R5: With `pd_sel`=0, entry is `cmd`=3 (self-refresh) with `cke`=0 in the same cycle.
- R6: `cke` stays low for at least `t_cke`+1 cycles, counting the entry cycle. A wake present from the entry cycle onward raises `cke` in exactly cycle `t_cke`+1 after entry.
- R7: Power-down is left when `acc_pend`=1, `rfsh_urgent`=1, `lp_en`=0 or `pd_sel`=0. The cycle in which `cke` rises carries `cmd`=0 with `acc_ok`=0, and `acc_ok` returns to 1 in the next cycle.
- R8: After an access that woke the block is served and `acc_pend` falls, the block re-enters power-down without any change to the control bits.
- R9: Self-refresh is left when `acc_pend`=1, `lp_en`=0 or `pd_sel`=1. `rfsh_urgent` has no effect while in self-refresh.
- R10: On leaving self-refresh, `cmd`=0 is issued for `t_sxnr`+1 cycles starting with the cycle `cke` rises. The next cycle issues `cmd`=4 (auto-refresh), and `acc_ok` stays 0 until the cycle after that.
- R11: If the entry condition is lost during the precharge-all cycle, the block returns to normal service with `cke`=1 and no entry command.
- R12: `t_cke` and `t_sxnr` are sampled at the deciding edge. Changing them while `cke` is low has no effect on the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_en | input | 1 | Low-power enable control bit |
| pd_sel | input | 1 | 1 selects power-down, 0 selects self-refresh |
| acc_pend | input | 1 | A memory access is outstanding |
| rfsh_backlog | input | BW | Number of refreshes owed |
| rfsh_urgent | input | 1 | Refresh backlog has reached its must-refresh level |
| bank_open | input | NB | One bit per bank with an open row |
| t_cke | input | TW | Minimum low-CKE residency minus one, in cycles |
| t_sxnr | input | TW | NOP cycles after self-refresh exit, minus one |
| cke | output | 1 | Clock enable to the memory |
| cmd | output | 3 | Command code: 0 NOP, 1 precharge-all, 2 power-down, 3 self-refresh, 4 auto-refresh |
| acc_ok | output | 1 | The controller may issue accesses this cycle |

## Verification
A wrong state here shows at the ports in the same cycle, because `cke`, `cmd` and `acc_ok` decode directly from the state register. A residency counter that is off by one moves the `cke` rise by exactly one cycle. A lost precharge step removes the one-cycle `cmd`=1 before the fall of `cke`. A skipped refresh after self-refresh shows as a rise of `acc_ok` with no `cmd`=4 in front of it. Wrong drain logic makes `cke` fall while `acc_pend` or the backlog is nonzero, so it is seen at the edge where the fall happens.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [3:0] {
    S_RUN, S_PREA, S_PDE, S_PD, S_PXIT, S_SRE, S_SR, S_SXW, S_SXREF
  } lpm_state_e;

  typedef enum logic [2:0] {
    C_NOP  = 3'd0,
    C_PREA = 3'd1,
    C_PDN  = 3'd2,
    C_SRE  = 3'd3,
    C_REF  = 3'd4
  } lpm_cmd_e;

  // CKE is held low in the entry and resident states of both modes
  function automatic logic state_cke(input lpm_state_e s);
    return !(s inside {S_PDE, S_PD, S_SRE, S_SR});
  endfunction

  function automatic lpm_cmd_e state_cmd(input lpm_state_e s);
    case (s)
      S_PREA:  return C_PREA;
      S_PDE:   return C_PDN;
      S_SRE:   return C_SRE;
      S_SXREF: return C_REF;
      default: return C_NOP;
    endcase
  endfunction

  function automatic logic state_grant(input lpm_state_e s);
    return s == S_RUN;
  endfunction

  // traffic is idle and low power is requested
  function automatic logic entry_ready(input logic en, input logic pend,
                                       input logic backlog_zero, input logic urgent);
    return en && !pend && backlog_zero && !urgent;
  endfunction

  function automatic logic pd_wake(input logic en, input logic sel,
                                   input logic pend, input logic urgent);
    return pend || urgent || !en || !sel;
  endfunction

  function automatic logic sr_wake(input logic en, input logic sel, input logic pend);
    return pend || !en || sel;
  endfunction

endpackage

// File: rtl/lpm_cond.sv
module lpm_cond #(
  parameter int BW = 6
) (
  input  logic          lp_en,
  input  logic          pd_sel,
  input  logic          acc_pend,
  input  logic [BW-1:0] rfsh_backlog,
  input  logic          rfsh_urgent,
  output logic          entry_ok,
  output logic          wake_pd,
  output logic          wake_sr
);
  import lpm_pkg::*;

  logic backlog_zero;

  always_comb begin
    backlog_zero = (rfsh_backlog == '0);
    entry_ok     = entry_ready(lp_en, acc_pend, backlog_zero, rfsh_urgent);
    wake_pd      = pd_wake(lp_en, pd_sel, acc_pend, rfsh_urgent);
    wake_sr      = sr_wake(lp_en, pd_sel, acc_pend);
  end

endmodule

// File: rtl/lpm_timer.sv
module lpm_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm #(
  parameter int TW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                entry_ok,
  input  logic                pd_sel,
  input  logic                wake_pd,
  input  logic                wake_sr,
  input  logic                any_open,
  input  logic                tmr_zero,
  input  logic [TW-1:0]       t_cke,
  input  logic [TW-1:0]       t_sxnr,
  output lpm_pkg::lpm_state_e state,
  output logic                tmr_load,
  output logic [TW-1:0]       tmr_val
);
  import lpm_pkg::*;

  lpm_state_e    st_q, st_d;
  logic [TW-1:0] xnr_q;
  logic          go_low;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = t_cke;
    go_low   = 1'b0;
    case (st_q)
      S_RUN: begin
        if (entry_ok) begin
          if (any_open) st_d = S_PREA;
          else begin
            st_d   = pd_sel ? S_PDE : S_SRE;
            go_low = 1'b1;
          end
        end
      end
      S_PREA: begin
        if (entry_ok) begin
          st_d   = pd_sel ? S_PDE : S_SRE;
          go_low = 1'b1;
        end else begin
          st_d = S_RUN;
        end
      end
      S_PDE, S_PD: st_d = (tmr_zero && wake_pd) ? S_PXIT : S_PD;
      S_PXIT:      st_d = S_RUN;
      S_SRE, S_SR: begin
        if (tmr_zero && wake_sr) begin
          st_d     = S_SXW;
          tmr_load = 1'b1;
          tmr_val  = xnr_q;
        end else begin
          st_d = S_SR;
        end
      end
      S_SXW:   if (tmr_zero) st_d = S_SXREF;
      S_SXREF: st_d = S_RUN;
      default: st_d = S_RUN;
    endcase
    if (go_low) tmr_load = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_RUN;
      xnr_q <= '0;
    end else begin
      st_q <= st_d;
      if (go_low) xnr_q <= t_sxnr;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/dram_lowpow_seq.sv
module dram_lowpow_seq #(
  parameter int NB = 4,
  parameter int BW = 6,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp_en,
  input  logic          pd_sel,
  input  logic          acc_pend,
  input  logic [BW-1:0] rfsh_backlog,
  input  logic          rfsh_urgent,
  input  logic [NB-1:0] bank_open,
  input  logic [TW-1:0] t_cke,
  input  logic [TW-1:0] t_sxnr,
  output logic          cke,
  output logic [2:0]    cmd,
  output logic          acc_ok
);
  import lpm_pkg::*;

  // named internal events, visible to the bound checker
  logic          entry_ok;
  logic          wake_pd;
  logic          wake_sr;
  logic          tmr_zero;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          any_open;
  lpm_state_e    state;

  assign any_open = |bank_open;

  lpm_cond #(.BW(BW)) u_cond (
    .lp_en        (lp_en),
    .pd_sel       (pd_sel),
    .acc_pend     (acc_pend),
    .rfsh_backlog (rfsh_backlog),
    .rfsh_urgent  (rfsh_urgent),
    .entry_ok     (entry_ok),
    .wake_pd      (wake_pd),
    .wake_sr      (wake_sr)
  );

  lpm_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  lpm_fsm #(.TW(TW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .entry_ok (entry_ok),
    .pd_sel   (pd_sel),
    .wake_pd  (wake_pd),
    .wake_sr  (wake_sr),
    .any_open (any_open),
    .tmr_zero (tmr_zero),
    .t_cke    (t_cke),
    .t_sxnr   (t_sxnr),
    .state    (state),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val)
  );

  always_comb begin
    cke    = state_cke(state);
    cmd    = 3'(state_cmd(state));
    acc_ok = state_grant(state);
  end

endmodule

// File: rtl/lpm_chk.sv
module lpm_chk #(
  parameter int NB = 4,
  parameter int BW = 6,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke,
  input logic [2:0]    cmd,
  input logic          acc_ok,
  input logic          acc_pend,
  input logic [BW-1:0] rfsh_backlog,
  input logic [NB-1:0] bank_open,
  input logic [TW-1:0] t_cke
);
  import lpm_pkg::*;

  logic [15:0]   low_cnt;
  logic [TW-1:0] cap;
  logic          sx_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt <= '0;
      cap     <= '0;
      sx_flag <= 1'b0;
    end else begin
      if (cke) begin
        low_cnt <= '0;
        cap     <= t_cke;
      end else if (low_cnt != 16'hFFFF) begin
        low_cnt <= low_cnt + 16'd1;
      end
      if (cmd == 3'(C_SRE))      sx_flag <= 1'b1;
      else if (cmd == 3'(C_REF)) sx_flag <= 1'b0;
    end
  end

  a_r6_min_residency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> int'(low_cnt) >= int'(cap) + 1);

  a_r2_drained_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> ($past(acc_pend) == 1'b0 && $past(rfsh_backlog) == '0));

  a_r3_banks_closed: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> ($past(bank_open) == '0 || $past(cmd) == 3'(C_PREA)));

  a_r4_entry_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cmd == 3'(C_PDN) || cmd == 3'(C_SRE)));

  a_r10_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
    (sx_flag && cke) |-> ((cmd == 3'(C_NOP) || cmd == 3'(C_REF)) && !acc_ok));

  a_r7_grant_awake: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |-> (cke && cmd == 3'(C_NOP)));

endmodule

bind dram_lowpow_seq lpm_chk #(.NB(NB), .BW(BW), .TW(TW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cke          (cke),
  .cmd          (cmd),
  .acc_ok       (acc_ok),
  .acc_pend     (acc_pend),
  .rfsh_backlog (rfsh_backlog),
  .bank_open    (bank_open),
  .t_cke        (t_cke)
);

// File: tb/sim_dram_lowpow_seq.sv
module sim_dram_lowpow_seq;
  localparam int NB = 4;
  localparam int BW = 6;
  localparam int TW = 4;
  localparam int NV = 8;

  // nibbles: mode(1=PD) | wake kind | bank mask | t_cke | t_sxnr
  // wake kind: 0 access, 1 urgent, 2 enable cleared, 3 select flipped
  localparam logic [19:0] VEC [NV] = '{
    20'h1_0_0_3_0,
    20'h1_1_5_0_0,
    20'h1_2_0_7_0,
    20'h1_3_8_1_0,
    20'h0_0_0_2_1,
    20'h0_2_3_0_0,
    20'h0_3_0_4_5,
    20'h0_2_F_F_F
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lp_en = 1'b0;
  logic          pd_sel = 1'b1;
  logic          acc_pend = 1'b0;
  logic [BW-1:0] rfsh_backlog = '0;
  logic          rfsh_urgent = 1'b0;
  logic [NB-1:0] bank_open = '0;
  logic [TW-1:0] t_cke = '0;
  logic [TW-1:0] t_sxnr = '0;
  logic          cke;
  logic [2:0]    cmd;
  logic          acc_ok;

  int n_tot = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dram_lowpow_seq #(.NB(NB), .BW(BW), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .lp_en(lp_en), .pd_sel(pd_sel),
    .acc_pend(acc_pend), .rfsh_backlog(rfsh_backlog), .rfsh_urgent(rfsh_urgent),
    .bank_open(bank_open), .t_cke(t_cke), .t_sxnr(t_sxnr),
    .cke(cke), .cmd(cmd), .acc_ok(acc_ok)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
      $finish;
    end
  endtask

  task automatic idle();
    lp_en = 1'b0; pd_sel = 1'b1; acc_pend = 1'b0;
    rfsh_backlog = '0; rfsh_urgent = 1'b0; bank_open = '0;
    for (int k = 0; k < 60 && !acc_ok; k++) tick();
    tick();
  endtask

  initial begin
    #(8 * 150000);
    n_tot++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int low;
    int nops;
    bit held_nop;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check(cke && cmd == 3'd0 && acc_ok, "R1 reset outputs", {cke, cmd, acc_ok}, 5'b10001);

    // table walk: entry, held wake, exit
    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      logic mode;
      logic [1:0] wk;
      logic [3:0] bk, tc, ts;
      v = VEC[i];
      mode = v[16]; wk = v[13:12]; bk = v[11:8]; tc = v[7:4]; ts = v[3:0];
      idle();
      t_cke = tc; t_sxnr = ts; pd_sel = mode; bank_open = bk; lp_en = 1'b1;
      tick();
      if (bk != 0) begin
        check(cmd == 3'd1 && cke, "R3 precharge before entry", cmd, 1);
        bank_open = '0;
        tick();
      end
      if (mode)
        check(!cke && cmd == 3'd2, "R4 power-down entry", {cke, cmd}, 2);
      else
        check(!cke && cmd == 3'd3, "R5 self-refresh entry", {cke, cmd}, 3);
      t_cke = ~tc; t_sxnr = ~ts;  // R12 changes while low must be ignored
      case (wk)
        2'd0: acc_pend = 1'b1;
        2'd1: rfsh_urgent = 1'b1;
        2'd2: lp_en = 1'b0;
        default: pd_sel = ~mode;
      endcase
      low = 1;
      held_nop = 1'b1;
      while (!cke && low < 40) begin
        tick();
        if (!cke) begin
          low++;
          if (cmd != 3'd0) held_nop = 1'b0;
        end
      end
      check(low == int'(tc) + 1, "R6 R12 low residency", low, int'(tc) + 1);
      check(held_nop, "R4 NOP while held low", held_nop, 1);
      check(cmd == 3'd0 && !acc_ok, mode ? "R7 exit cycle" : "R10 exit cycle",
            {cmd, acc_ok}, 0);
      lp_en = 1'b0; acc_pend = 1'b0; rfsh_urgent = 1'b0;
      if (mode) begin
        tick();
        check(acc_ok && cke && cmd == 3'd0, "R7 grant after exit", acc_ok, 1);
      end else begin
        nops = 1;
        while (cmd == 3'd0 && nops < 40) begin
          tick();
          if (cmd == 3'd0) nops++;
        end
        check(nops == int'(ts) + 1, "R10 R12 NOP count", nops, int'(ts) + 1);
        check(cmd == 3'd4 && !acc_ok && cke, "R10 auto-refresh first", cmd, 4);
        tick();
        check(acc_ok == 1'b1, "R10 grant after refresh", acc_ok, 1);
      end
    end

    // R2 drain gating
    idle();
    t_cke = 4'd2; pd_sel = 1'b1; lp_en = 1'b1; acc_pend = 1'b1;
    repeat (3) tick();
    check(cke && acc_ok, "R2 access pending blocks entry", cke, 1);
    acc_pend = 1'b0; rfsh_backlog = 6'd3;
    repeat (3) tick();
    check(cke && acc_ok, "R2 backlog blocks entry", cke, 1);
    rfsh_backlog = '0; rfsh_urgent = 1'b1;
    repeat (2) tick();
    check(cke, "R2 urgent blocks entry", cke, 1);
    rfsh_urgent = 1'b0;
    tick();
    check(!cke && cmd == 3'd2, "R2 entry after drain", {cke, cmd}, 2);

    // R8 serve an access then fall back into power-down
    acc_pend = 1'b1;
    repeat (2) tick();
    check(!cke, "R8 wake held during residency", cke, 0);
    tick();
    check(cke && cmd == 3'd0, "R8 wake raises cke", cke, 1);
    repeat (3) tick();
    check(acc_ok && cke, "R8 access served", acc_ok, 1);
    acc_pend = 1'b0;
    tick();
    check(!cke && cmd == 3'd2, "R8 automatic re-entry", {cke, cmd}, 2);
    lp_en = 1'b0;

    // R9 urgent refresh does not wake self-refresh
    idle();
    t_cke = 4'd0; t_sxnr = 4'd1; pd_sel = 1'b0; lp_en = 1'b1;
    tick();
    check(!cke && cmd == 3'd3, "R5 self-refresh entry", {cke, cmd}, 3);
    rfsh_urgent = 1'b1;
    repeat (5) tick();
    check(!cke, "R9 urgent ignored in self-refresh", cke, 0);
    acc_pend = 1'b1;
    tick();
    check(cke && cmd == 3'd0, "R9 access wakes self-refresh", cke, 1);
    lp_en = 1'b0; acc_pend = 1'b0; rfsh_urgent = 1'b0;

    // R11 abort during precharge
    idle();
    pd_sel = 1'b1; bank_open = 4'b0010; lp_en = 1'b1;
    tick();
    check(cmd == 3'd1 && cke, "R11 precharge issued", cmd, 1);
    acc_pend = 1'b1;
    tick();
    check(cke && cmd == 3'd0 && acc_ok, "R11 entry abandoned", {cke, cmd, acc_ok}, 5'b10001);
    tick();
    check(cke, "R11 stays awake", cke, 1);
    idle();

    finish_run();
  end

endmodule